// File: doc/BRIEF.md
# Single-Precision to 16-bit Float Quantizer

This block narrows an IEEE-754 single-precision word into a compact 16-bit floating-point code: one sign bit, a 6-bit exponent with bias 31, and a 9-bit fraction with a hidden leading one. It is placed where low-precision copies of 32-bit master weights are produced. Each accepted input yields one registered result one cycle later, together with an exception flag.

The target code has no subnormals. It has a single unsigned zero and a single merged NaN/infinity code whose sign is irrelevant. Every other encoding, including exponent 0 with a nonzero fraction and exponent 63 with a fraction below all-ones, is an ordinary normal value. The fraction is rounded to nearest with ties going up, and only the first discarded bit decides the rounding.

Top module: `fp32_narrow_quant`

## Requirements
- R1: A normal input with unbiased exponent E and rounded fraction m is encoded as {sign, E+31, m}: sign in bit 15, exponent in bits 14:9, fraction in bits 8:0. The value is (-1)^s * 2^(e-31) * (1 + m/512).
- R2: The kept fraction is input bits 22:14. One is added when input bit 13 is 1, and input bits 12:0 have no effect on the result.
- R3: When rounding carries out of the 9-bit fraction, the fraction becomes 0 and the target exponent rises by one.
- R4: An input with exponent field 255 (infinity or NaN, either sign) produces 16'h7FFF with the exception flag set.
- R5: A rounded result whose target exponent exceeds 63, or equals 63 with fraction 511, produces 16'h7FFF with the flag set. Exponent 63 with fraction 510 (16'h7FFE, or 16'hFFFE when negative) is the largest finite result, and its flag is clear.
- R6: Input zeros, input subnormals, and any rounded magnitude below 2^-31 * (1 + 1/512) produce 16'h0000 with the flag clear. This covers a target exponent below 0, and exponent 0 with fraction 0.
- R7: The zero and NaN/infinity results always carry sign bit 0. The exception flag is set exactly when the result is 16'h7FFF.
- R8: valid_o equals valid_i delayed by one cycle. data_o and exc_o update only in cycles where valid_i is high, and otherwise hold their previous values.
- R9: While rst_ni is low, valid_o, data_o and exc_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input word is valid this cycle |
| data_i | input | 32 | Single-precision input word |
| valid_o | output | 1 | Result is valid (one cycle after valid_i) |
| data_o | output | 16 | 16-bit float result |
| exc_o | output | 1 | Result is the NaN/infinity code |

## Verification
The bench uses the default widths: a 6-bit exponent, a 9-bit fraction and bias 31. With these widths both range edges are exact single-precision values, so the directed cases can hit them bit for bit. On the low side these are 2^-31, the smallest nonzero result, and the round-up into zero from exponent -32. On the high side they are the largest finite code and its rounding neighbour that overflows. A pseudo-random sweep uses exponents shaped to straddle both edges, with irregular gaps in valid_i. Each result is compared with a real-number model that normalizes and rounds the magnitude arithmetically instead of slicing bits.

// File: rtl/qf_pkg.sv
package qf_pkg;
  localparam int SRC_W      = 32;
  localparam int SRC_EXP_W  = 8;
  localparam int SRC_FRAC_W = 23;
  localparam int SRC_BIAS   = 127;

  typedef enum logic [1:0] {
    CLS_ZERO    = 2'd0,
    CLS_NORM    = 2'd1,
    CLS_SPECIAL = 2'd2
  } cls_e;
endpackage

// File: rtl/qf_unpack.sv
module qf_unpack
  import qf_pkg::*;
(
  input  logic [SRC_W-1:0]      word_i,
  output logic                  sign_o,
  output cls_e                  cls_o,
  output logic [SRC_EXP_W-1:0]  exp_o,
  output logic [SRC_FRAC_W-1:0] frac_o
);
  assign sign_o = word_i[SRC_W-1];
  assign exp_o  = word_i[SRC_W-2 -: SRC_EXP_W];
  assign frac_o = word_i[SRC_FRAC_W-1:0];

  // subnormal inputs sit far below the target range: treat as zero
  always_comb begin
    if (&exp_o)             cls_o = CLS_SPECIAL;
    else if (exp_o == '0)   cls_o = CLS_ZERO;
    else                    cls_o = CLS_NORM;
  end
endmodule

// File: rtl/qf_round.sv
module qf_round #(
  parameter int SRC_FRAC_W = 23,
  parameter int DST_FRAC_W = 9
) (
  input  logic [SRC_FRAC_W-1:0] frac_i,
  output logic [DST_FRAC_W-1:0] frac_o,
  output logic                  carry_o
);
  localparam int DROP_W = SRC_FRAC_W - DST_FRAC_W;

  logic [DST_FRAC_W-1:0] keep;
  logic                  guard;
  logic [DST_FRAC_W:0]   sum;

  assign keep  = frac_i[SRC_FRAC_W-1 -: DST_FRAC_W];
  assign guard = frac_i[DROP_W-1];

  // nearest-up: bits below the guard never influence the result
  generate
    if (DROP_W > 1) begin : g_tail
      logic [DROP_W-2:0] unused_tail;
      assign unused_tail = frac_i[DROP_W-2:0];
    end
  endgenerate

  assign sum     = {1'b0, keep} + {{DST_FRAC_W{1'b0}}, guard};
  assign frac_o  = sum[DST_FRAC_W-1:0];
  assign carry_o = sum[DST_FRAC_W];
endmodule

// File: rtl/qf_pack.sv
module qf_pack
  import qf_pkg::*;
#(
  parameter int DST_EXP_W  = 6,
  parameter int DST_FRAC_W = 9,
  parameter int DST_BIAS   = 31
) (
  input  logic                             sign_i,
  input  cls_e                             cls_i,
  input  logic [SRC_EXP_W-1:0]             exp_i,
  input  logic [DST_FRAC_W-1:0]            frac_i,
  input  logic                             carry_i,
  output logic [DST_EXP_W+DST_FRAC_W:0]    code_o,
  output logic                             exc_o
);
  localparam int OUT_W = DST_EXP_W + DST_FRAC_W + 1;
  localparam int E_MAX = (1 << DST_EXP_W) - 1;
  localparam logic [OUT_W-1:0] NAN_CODE = {1'b0, {(OUT_W-1){1'b1}}};

  int                   e_calc;
  logic [DST_EXP_W-1:0] e_trim;

  always_comb begin
    e_calc = int'(exp_i) - SRC_BIAS + DST_BIAS + int'(carry_i);
    e_trim = DST_EXP_W'(e_calc);
    code_o = '0;
    exc_o  = 1'b0;
    unique case (cls_i)
      CLS_SPECIAL: begin
        code_o = NAN_CODE;
        exc_o  = 1'b1;
      end
      CLS_NORM: begin
        if (e_calc < 0) begin
          code_o = '0;
        end else if (e_calc > E_MAX || (e_calc == E_MAX && &frac_i)) begin
          code_o = NAN_CODE;
          exc_o  = 1'b1;
        end else if (e_calc == 0 && frac_i == '0) begin
          code_o = '0;
        end else begin
          code_o = {sign_i, e_trim, frac_i};
        end
      end
      default: code_o = '0;
    endcase
  end
endmodule

// File: rtl/fp32_narrow_quant.sv
module fp32_narrow_quant
  import qf_pkg::*;
#(
  parameter int DST_EXP_W  = 6,
  parameter int DST_FRAC_W = 9,
  parameter int DST_BIAS   = 31
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              valid_i,
  input  logic [SRC_W-1:0]                  data_i,
  output logic                              valid_o,
  output logic [DST_EXP_W+DST_FRAC_W:0]     data_o,
  output logic                              exc_o
);
  localparam int OUT_W = DST_EXP_W + DST_FRAC_W + 1;
  localparam logic [OUT_W-1:0] NAN_CODE = {1'b0, {(OUT_W-1){1'b1}}};

  logic                  in_sign;
  cls_e                  in_cls;
  logic [SRC_EXP_W-1:0]  in_exp;
  logic [SRC_FRAC_W-1:0] in_frac;
  logic [DST_FRAC_W-1:0] rnd_frac;
  logic                  rnd_carry;
  logic [OUT_W-1:0]      res_code;
  logic                  res_exc;

  qf_unpack u_unpack (
    .word_i (data_i),
    .sign_o (in_sign),
    .cls_o  (in_cls),
    .exp_o  (in_exp),
    .frac_o (in_frac)
  );

  qf_round #(
    .SRC_FRAC_W (SRC_FRAC_W),
    .DST_FRAC_W (DST_FRAC_W)
  ) u_round (
    .frac_i  (in_frac),
    .frac_o  (rnd_frac),
    .carry_o (rnd_carry)
  );

  qf_pack #(
    .DST_EXP_W  (DST_EXP_W),
    .DST_FRAC_W (DST_FRAC_W),
    .DST_BIAS   (DST_BIAS)
  ) u_pack (
    .sign_i  (in_sign),
    .cls_i   (in_cls),
    .exp_i   (in_exp),
    .frac_i  (rnd_frac),
    .carry_i (rnd_carry),
    .code_o  (res_code),
    .exc_o   (res_exc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      exc_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        data_o <= res_code;
        exc_o  <= res_exc;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);                                              // R8
  AST_VALID_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);                                            // R8
  AST_HOLD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(data_o) && $stable(exc_o)));                 // R8
  AST_FLAG_MATCHES_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (exc_o == (data_o == NAN_CODE)));                      // R7
  AST_UNSIGNED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && data_o[OUT_W-2:0] == '0) |-> !data_o[OUT_W-1]);        // R7
  AST_SPECIAL_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && &data_i[SRC_W-2 -: SRC_EXP_W]) |=> (exc_o && data_o == NAN_CODE)); // R4
  AST_ZERO_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && data_i[SRC_W-2 -: SRC_EXP_W] == '0) |=> (data_o == '0 && !exc_o)); // R6
endmodule

// File: tb/sim_fp32_narrow_quant.sv
`timescale 1ns/1ps
module sim_fp32_narrow_quant;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] data_i = '0;
  logic        valid_o;
  logic [15:0] data_o;
  logic        exc_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [16:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  fp32_narrow_quant u0 (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .data_i  (data_i),
    .valid_o (valid_o),
    .data_o  (data_o),
    .exc_o   (exc_o)
  );

  // real-number reference: {flag, code}
  function automatic logic [16:0] ref_model(input logic [31:0] w);
    int  ex, k, m, e;
    real mag, f;
    ex = int'(w[30:23]);
    if (ex == 255) return {1'b1, 16'h7FFF};
    if (ex == 0)   return 17'h0;
    mag = (1.0 + real'(w[22:0]) / 8388608.0) * (2.0 ** (real'(ex) - 127.0));
    k = 0;
    while (mag >= 2.0) begin mag = mag / 2.0; k++; end
    while (mag < 1.0)  begin mag = mag * 2.0; k--; end
    f = (mag - 1.0) * 512.0;
    m = $rtoi(f);
    if (f - real'(m) >= 0.5) m++;
    if (m == 512) begin m = 0; k++; end
    e = k + 31;
    if (e < 0 || (e == 0 && m == 0)) return 17'h0;
    if (e > 63 || (e == 63 && m == 511)) return {1'b1, 16'h7FFF};
    return {1'b0, w[31], 6'(e), 9'(m)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic send(input logic [31:0] w, input string tag);
    @(negedge clk);
    valid_i = 1'b1;
    data_i  = w;
    exp_q.push_back(ref_model(w));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n, input logic [31:0] w);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
      data_i  = w;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_ni && valid_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8", "unexpected valid_o", {15'h0, exc_o, data_o}, 32'h0);
      end else begin
        logic [16:0] e;
        string       t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({exc_o, data_o} == e, t, "result", {15'h0, exc_o, data_o}, {15'h0, e});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R8 watchdog: actual=running expected=finished");
    report();
  end

  initial begin
    bit [31:0] st;
    logic [31:0] w;
    // R9: reset state, input activity ignored
    valid_i = 1'b1;
    data_i  = 32'h3F800000;
    repeat (3) @(negedge clk);
    chk(valid_o == 1'b0, "R9", "valid_o in reset", {31'h0, valid_o}, 32'h0);
    chk(data_o == 16'h0, "R9", "data_o in reset", {16'h0, data_o}, 32'h0);
    chk(exc_o == 1'b0, "R9", "exc_o in reset", {31'h0, exc_o}, 32'h0);
    valid_i = 1'b0;
    rst_ni  = 1'b1;
    idle(2, 32'h0);

    // R1 plain conversions
    send(32'h3F800000, "R1");   // 1.0   -> 3E00
    send(32'hC0200000, "R1");   // -2.5  -> C080
    send(32'h42F60000, "R1");   // 123.0
    // R2 guard-only rounding
    send(32'h3F802000, "R2");   // guard set -> 3E01
    send(32'h3F801FFF, "R2");   // only lower bits -> 3E00
    send(32'hBF803FFF, "R2");
    // R3 carry into exponent
    send(32'h3FFFE000, "R3");   // -> 4000
    send(32'hC07FF000, "R3");
    // R4 specials
    send(32'h7FC00000, "R4");
    send(32'h7F800000, "R4");
    send(32'hFF800000, "R4");
    send(32'hFFC00001, "R4");
    // R5 top of range
    send(32'h4FFF8000, "R5");   // largest -> 7FFE
    send(32'hCFFF8000, "R5");   // -> FFFE
    send(32'h4FFFC000, "R5");   // rounds to 63/511 -> 7FFF
    send(32'h4FFFE000, "R5");   // carry past 63
    send(32'h53800000, "R5");   // 2^40
    // R6/R7 bottom of range and zeros
    send(32'h30000000, "R6");   // 2^-31 -> zero
    send(32'hB0000000, "R7");   // -2^-31 -> unsigned zero
    send(32'h30004000, "R6");   // smallest nonzero -> 0001
    send(32'hB0004000, "R6");   // -> 8001
    send(32'h2FFFE000, "R6");   // rounds into e=0,m=0 -> zero
    send(32'h2FFFF000, "R6");
    send(32'h2E000000, "R6");
    send(32'h00000000, "R6");
    send(32'h80000000, "R7");
    send(32'h00000001, "R6");
    send(32'h807FFFFF, "R7");

    // R8 hold while idle
    send(32'h3F800000, "R1");
    idle(2, 32'h7F800000);
    chk(valid_o == 1'b0, "R8", "valid_o idle", {31'h0, valid_o}, 32'h0);
    chk({exc_o, data_o} == 17'h03E00, "R8", "held result", {15'h0, exc_o, data_o}, 32'h3E00);
    send(32'hFF800000, "R4");
    idle(2, 32'h3F800000);
    chk({exc_o, data_o} == 17'h17FFF, "R8", "held flag", {15'h0, exc_o, data_o}, 32'h17FFF);

    // sweep with irregular gaps
    st = 32'h1234ABCD;
    for (int i = 0; i < 400; i++) begin
      st ^= st << 13;
      st ^= st >> 17;
      st ^= st << 5;
      w = st;
      if (i % 2 == 1) w[30:23] = 8'd86 + 8'(st[7:0] % 8'd84);
      send(w, "R1");
      if (st[9]) idle(1, ~st);
    end

    idle(4, 32'h0);
    chk(exp_q.size() == 0, "R8", "all results returned", exp_q.size(), 32'h0);
    report();
  end
endmodule